// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This unit holds the program counter of a 32-bit load/store core and picks, every cycle, the address the next instruction is fetched from. The decode stage hands it a control class for the instruction at the current fetch address, together with that instruction's 16-bit offset field, its 26-bit jump field, the two register operands to compare and a register value for indirect jumps. At the next rising clock edge the counter moves to one of four addresses:

- the next sequential word;
- a PC-relative branch target;
- a pseudodirect target built from the upper PC bits and the jump field;
- a register-supplied address.

For subroutine calls the unit also raises a write request toward register 31 in the same cycle. The request carries the return address, which is the address of the instruction after the call. An indirect jump to an address that is not word aligned is flagged. The counter still moves, to the aligned word that contains that address.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `fetchAddr` loads the parameter `RESET_VEC` (default 0). The bench uses the default value.
- R2: Class code 0 (sequential) advances `fetchAddr` by 4 at the next edge. Unused codes 6 and 7 behave the same way.
- R3: Class code 1 (branch-if-equal) loads `fetchAddr + 4 + (sign-extended imm16 << 2)` when `opA == opB`. Otherwise it loads `fetchAddr + 4`.
- R4: Class code 2 (branch-if-not-equal) loads the same PC-relative target when `opA != opB`. Otherwise it loads `fetchAddr + 4`.
- R5: Class code 3 (jump) loads `{pcPlus4[31:28], jumpField, 2'b00}`. For example, a field value of 2500 reaches byte address 10000 when the upper four bits are zero.
- R6: Class code 4 (jump-and-link) loads the same pseudodirect target as R5. In the same cycle it drives `linkWe` high, `linkAddr = fetchAddr + 4` and `linkReg = 31`. `linkWe` is low for every other class.
- R7: Class code 5 (jump-register) loads `regTarget` with its two low bits cleared.
- R8: `misaligned` is high in a cycle exactly when the class is 5 and `regTarget[1:0]` is not zero.
- R9: `fetchAddr[1:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlClass | input | 3 | Control class of the current instruction (codes in R2 to R7) |
| imm16 | input | 16 | Branch offset field, counted in words |
| jumpField | input | 26 | Pseudodirect word-address field |
| opA | input | 32 | First comparison operand |
| opB | input | 32 | Second comparison operand |
| regTarget | input | 32 | Target address for jump-register |
| fetchAddr | output | 32 | Current program counter / fetch address |
| linkWe | output | 1 | Request to write the return address |
| linkReg | output | 5 | Destination register of the link write (31) |
| linkAddr | output | 32 | Return address, fetchAddr + 4 |
| misaligned | output | 1 | Jump-register target not word aligned |

## Verification
Both conditional branches are tried with equal operands and with operands that differ only in a single low or high bit. This shows whether the compare covers the whole word and whether taken and not-taken are swapped between the two classes. Branch offsets are applied forward, backward and as zero, which tells a sign-extended and shifted offset apart from an unshifted or zero-extended one. Jumps are issued from a counter whose upper four bits are nonzero, so that a missing upper-bit merge shows up. Indirect jumps use both aligned and misaligned targets, and a reset is applied in the middle of a call sequence.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 16;
  localparam int JF_W   = 26;
  localparam int REG_W  = 5;
  localparam int UPPER_W = ADDR_W - JF_W - 2;
  localparam logic [REG_W-1:0] LINK_REG = '1;

  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_BEQ  = 3'd1,
    CLS_BNE  = 3'd2,
    CLS_JMP  = 3'd3,
    CLS_JAL  = 3'd4,
    CLS_JREG = 3'd5
  } ctrl_class_e;

  typedef struct packed {
    logic selBranch;
    logic selJump;
    logic selReg;
    logic linkWe;
  } npc_strobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [2:0]  ctrlClass,
  input  logic        opsEqual,
  input  logic        tgtLowSet,
  output npc_strobe_t strobes,
  output logic        misaligned
);
  always_comb begin
    strobes    = '0;
    misaligned = 1'b0;
    case (ctrlClass)
      CLS_BEQ:  strobes.selBranch = opsEqual;
      CLS_BNE:  strobes.selBranch = ~opsEqual;
      CLS_JMP:  strobes.selJump   = 1'b1;
      CLS_JAL: begin
        strobes.selJump = 1'b1;
        strobes.linkWe  = 1'b1;
      end
      CLS_JREG: begin
        strobes.selReg = 1'b1;
        misaligned     = tgtLowSet;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
)(
  input  logic              clk,
  input  logic              rst,
  input  npc_strobe_t       strobes,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JF_W-1:0]   jumpField,
  input  logic [ADDR_W-1:0] opA,
  input  logic [ADDR_W-1:0] opB,
  input  logic [ADDR_W-1:0] regTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pcPlus4,
  output logic              opsEqual,
  output logic              tgtLowSet
);
  logic [ADDR_W-1:0] branchOffset;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] nextPc;

  assign pcPlus4      = pc + ADDR_W'(4);
  assign branchOffset = {{(ADDR_W-IMM_W-2){imm16[IMM_W-1]}}, imm16, 2'b00};
  assign branchTarget = pcPlus4 + branchOffset;
  assign jumpTarget   = {pcPlus4[ADDR_W-1 -: UPPER_W], jumpField, 2'b00};
  assign opsEqual     = (opA == opB);
  assign tgtLowSet    = |regTarget[1:0];

  always_comb begin
    if (strobes.selReg)         nextPc = {regTarget[ADDR_W-1:2], 2'b00};
    else if (strobes.selJump)   nextPc = jumpTarget;
    else if (strobes.selBranch) nextPc = branchTarget;
    else                        nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_VEC;
    else     pc <= nextPc;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  ctrlClass,
  input  logic [15:0] imm16,
  input  logic [25:0] jumpField,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] regTarget,
  output logic [31:0] fetchAddr,
  output logic        linkWe,
  output logic [4:0]  linkReg,
  output logic [31:0] linkAddr,
  output logic        misaligned
);
  npc_strobe_t strobes;
  logic        opsEqual;
  logic        tgtLowSet;
  logic [31:0] pcPlus4;

  npc_ctrl u_ctrl (
    .ctrlClass (ctrlClass),
    .opsEqual  (opsEqual),
    .tgtLowSet (tgtLowSet),
    .strobes   (strobes),
    .misaligned(misaligned)
  );

  npc_datapath #(.RESET_VEC(RESET_VEC)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .imm16    (imm16),
    .jumpField(jumpField),
    .opA      (opA),
    .opB      (opB),
    .regTarget(regTarget),
    .pc       (fetchAddr),
    .pcPlus4  (pcPlus4),
    .opsEqual (opsEqual),
    .tgtLowSet(tgtLowSet)
  );

  assign linkWe   = strobes.linkWe;
  assign linkReg  = LINK_REG;
  assign linkAddr = pcPlus4;
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker #(
  parameter logic [31:0] RESET_VEC = 32'h0
)(
  input logic        clk,
  input logic        rst,
  input logic [2:0]  ctrlClass,
  input logic [31:0] regTarget,
  input logic [31:0] fetchAddr,
  input logic        linkWe,
  input logic [4:0]  linkReg,
  input logic [31:0] linkAddr,
  input logic        misaligned
);
  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> fetchAddr == RESET_VEC);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 3'd0) |=> fetchAddr == $past(fetchAddr) + 32'd4);

  p_link_req_r6: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> (ctrlClass == 3'd4 && linkReg == 5'd31 && linkAddr == fetchAddr + 32'd4));

  p_jreg_load_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 3'd5) |=> fetchAddr == {$past(regTarget[31:2]), 2'b00});

  p_misalign_src_r8: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (ctrlClass == 3'd5 && regTarget[1:0] != 2'b00));

  p_word_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    fetchAddr[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_checker #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .ctrlClass(ctrlClass), .regTarget(regTarget),
  .fetchAddr(fetchAddr), .linkWe(linkWe), .linkReg(linkReg),
  .linkAddr(linkAddr), .misaligned(misaligned)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ctrlClass = '0;
  logic [15:0] imm16 = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] opA = '0, opB = '0, regTarget = '0;
  logic [31:0] fetchAddr, linkAddr;
  logic        linkWe, misaligned;
  logic [4:0]  linkReg;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] expPc;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  logic [31:0] modelPc;

  always #10 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .ctrlClass(ctrlClass), .imm16(imm16),
    .jumpField(jumpField), .opA(opA), .opB(opB), .regTarget(regTarget),
    .fetchAddr(fetchAddr), .linkWe(linkWe), .linkReg(linkReg),
    .linkAddr(linkAddr), .misaligned(misaligned)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares fetch address after each edge against the queue
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(fetchAddr == e.expPc, e.tag, fetchAddr, e.expPc);
        check(fetchAddr[1:0] == 2'b00, "R9 alignment", fetchAddr, {fetchAddr[31:2], 2'b00});
      end
    end
  end

  // driver: applies one instruction at the falling edge, checks link and flag, queues next PC
  task automatic step(input logic [2:0] cls, input logic [15:0] im, input logic [25:0] jf,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] tgt,
                      input bit doRst, input string tag);
    logic [31:0] p4, nxt, boff;
    bit expLink, expMis;
    @(negedge clk);
    ctrlClass = cls; imm16 = im; jumpField = jf; opA = a; opB = b; regTarget = tgt; rst = doRst;
    p4   = modelPc + 32'd4;
    boff = {{14{im[15]}}, im, 2'b00};
    expLink = (cls == 3'd4);
    expMis  = (cls == 3'd5) && (tgt[1:0] != 2'b00);
    case (cls)
      3'd1: nxt = (a == b) ? p4 + boff : p4;
      3'd2: nxt = (a != b) ? p4 + boff : p4;
      3'd3, 3'd4: nxt = {p4[31:28], jf, 2'b00};
      3'd5: nxt = {tgt[31:2], 2'b00};
      default: nxt = p4;
    endcase
    if (doRst) nxt = 32'h0;
    #1;
    if (!doRst) begin
      check(linkWe == expLink, {"R6 linkWe ", tag}, {31'b0, linkWe}, {31'b0, expLink});
      if (expLink) begin
        check(linkAddr == p4, "R6 linkAddr", linkAddr, p4);
        check(linkReg == 5'd31, "R6 linkReg", {27'b0, linkReg}, 32'd31);
      end
      check(misaligned == expMis, {"R8 misaligned ", tag}, {31'b0, misaligned}, {31'b0, expMis});
    end
    expQ.push_back('{nxt, tag});
    modelPc = nxt;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(fetchAddr == 32'h0, "R1 reset state", fetchAddr, 32'h0);
    modelPc = 32'h0;
    step(3'd0, 16'h0, 26'h0, 0, 0, 0, 1'b0, "R2 seq");
    step(3'd0, 16'h0, 26'h0, 0, 0, 0, 1'b0, "R2 seq again");
    step(3'd6, 16'h7, 26'h5, 1, 1, 32'h100, 1'b0, "R2 unused code 6");
    step(3'd7, 16'h7, 26'h5, 1, 2, 32'h103, 1'b0, "R2 unused code 7");
    step(3'd1, 16'h0004, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 1'b0, "R3 beq taken fwd");
    step(3'd1, 16'h0004, 26'h0, 32'h8000_0000, 32'h0, 0, 1'b0, "R3 beq not taken hi bit");
    step(3'd1, 16'hFFFC, 26'h0, 32'h5, 32'h5, 0, 1'b0, "R3 beq taken backward");
    step(3'd1, 16'h0000, 26'h0, 32'h7, 32'h7, 0, 1'b0, "R3 beq zero offset");
    step(3'd2, 16'h0010, 26'h0, 32'h1, 32'h0, 0, 1'b0, "R4 bne taken low bit");
    step(3'd2, 16'h0010, 26'h0, 32'h9, 32'h9, 0, 1'b0, "R4 bne not taken");
    step(3'd2, 16'hFFF0, 26'h0, 32'h0, 32'h4000_0000, 0, 1'b0, "R4 bne taken backward");
    step(3'd3, 16'h0, 26'd2500, 0, 0, 0, 1'b0, "R5 jump 2500");
    step(3'd5, 16'h0, 26'h0, 0, 0, 32'hF000_0040, 1'b0, "R7 jreg aligned");
    step(3'd3, 16'h0, 26'd2500, 0, 0, 0, 1'b0, "R5 jump keeps upper bits");
    step(3'd4, 16'h0, 26'h3_0000, 0, 0, 0, 1'b0, "R6 jal target");
    step(3'd5, 16'h0, 26'h0, 0, 0, 32'h0000_1233, 1'b0, "R7 R8 jreg misaligned");
    step(3'd5, 16'h0, 26'h0, 0, 0, 32'h0000_2002, 1'b0, "R7 R8 jreg misaligned 2");
    step(3'd4, 16'h0, 26'h12, 0, 0, 32'h3, 1'b0, "R6 jal second");
    step(3'd5, 16'h0, 26'h0, 0, 0, 32'h3, 1'b1, "R1 mid-run reset");
    step(3'd0, 16'h0, 26'h0, 0, 0, 0, 1'b0, "R2 seq after reset");
    @(negedge clk);
    ctrlClass = 3'd0;
    repeat (2) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule